// File: doc/BRIEF.md
# Multi-Dimensional DMA Address Generator

This block produces the source and destination addresses for one DMA channel. Each side can walk a constant address, a linear run, a two-dimensional table or a three-dimensional collection of tables. A single counter register steps once per transferred word and is shared by both sides. Depending on the configuration, the counter is treated as one field, two fields or three fields. When a field runs out it reloads from a stored preload copy. While that field is nonzero the address moves by one. Once the field has reached zero, the address moves by a selected signed offset instead. This one mechanism covers circular buffers, strided access and nested tables.

Software-side logic loads the start addresses, the counter value and the mode configuration while the channel is idle, then starts the channel. The transfer engine pulses `advance_i` once per completed word. After the last word of a block, the block raises `done_o` for one cycle, returns to idle, and holds the counter at its preload again, ready for a restart.

Top module: `mdma_addr_gen`

## Requirements
- R1: After synchronous reset, both address outputs, `count_o`, `done_o` and `busy_o` are all zero.
- R2: When `load_i` is seen while idle, the two start addresses, the counter and its preload copy are captured. When `load_i` is seen while busy, it changes no output and leaves the preload untouched, so the block later reloads the value from the earlier load.
- R3: Single-counter mode is used when both side modes are 100 or 101. The block runs preload+1 words: each word with a nonzero count decrements it. A word taken with count zero is the last one: it reloads the preload, pulses `done_o` and clears `busy_o`.
- R4: Side mode 101 adds one to the address on every word. Side mode 100 keeps the address constant.
- R5: Dual-counter mode splits the count into high bits 23:12 and low bits 11:0 and runs (low+1)×(high+1) words. With start S, offset T, high=1 and low=2, the addresses after each word are S+1, S+2, S+T+2, S+T+3, S+T+4 and S+2T+4. The counter is then back at its preload.
- R6: Side mode codes 000 to 011 select two-dimensional walking with offset register 0 to 3. The selected offset is added on any word taken while the low field is zero. On all other words the address adds one.
- R7: Offsets are added as 24-bit two's complement with wraparound. A negative offset therefore returns a circular buffer to its start, and it wraps below address zero.
- R8: With `tri_en_i` set, the counter has three fields (high/mid/low), selected by `tri_layout_i`: 00 gives 23:12/11:6/5:0, 01 gives 23:18/17:6/5:0, 10 gives 23:18/17:12/11:0, and 11 acts as 00. On the three-dimensional side, a word with low zero and mid nonzero adds the first offset of the pair. A word with low and mid both zero adds the second offset.
- R9: `tri_dst_i` picks the three-dimensional side (0 = source, 1 = destination). `tri_pair_i` picks offsets 0/1 (0) or 2/3 (1). The other side keeps its own mode, and a two-dimensional mode on that side tests only the low field.
- R10: If one side is two-dimensional and the other is 100 or 101, with `tri_en_i` clear, the dual-counter split is used.
- R11: `advance_i` has no effect while idle. `done_o` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Capture start addresses, counter and configuration (idle only) |
| start_i | input | 1 | Enter the busy state (idle only) |
| advance_i | input | 1 | One word has been transferred |
| src_start_i | input | AW | Source start address |
| dst_start_i | input | AW | Destination start address |
| count_i | input | CW | Counter preload value |
| src_mode_i | input | 3 | Source address mode |
| dst_mode_i | input | 3 | Destination address mode |
| tri_en_i | input | 1 | Three-dimensional transfer |
| tri_dst_i | input | 1 | Destination is the three-dimensional side |
| tri_layout_i | input | 2 | Triple-counter field layout |
| tri_pair_i | input | 1 | Offset pair for the three-dimensional side |
| offsets_i | input | 4*AW | Four shared signed offsets, offset k in bits k*AW+AW-1:k*AW |
| src_addr_o | output | AW | Current source address |
| dst_addr_o | output | AW | Current destination address |
| count_o | output | CW | Live counter value |
| done_o | output | 1 | One-cycle pulse after the last word of a block |
| busy_o | output | 1 | Channel active |

## Verification
The stimulus runs the same counter in single, dual and each of the triple layouts. A count that happens to have the same fields under two layouts tells those layouts apart only through the address step taken, so the layout tests use counts whose field positions differ between layouts. Distinct values are placed in all four offset registers so that a wrong offset code or a wrong pair select shows as a wrong address. One side is kept on a simpler mode so that the right-justified low-field test of the partner side is exposed. A negative offset, both within a buffer and across address zero, checks that the arithmetic wraps.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  typedef enum logic [1:0] {
    LAY_C   = 2'b00,
    LAY_D   = 2'b01,
    LAY_E   = 2'b10,
    LAY_RSV = 2'b11
  } tri_layout_e;

  typedef enum logic [1:0] {
    CM_SINGLE = 2'b00,
    CM_DUAL   = 2'b01,
    CM_TRIPLE = 2'b10
  } cnt_mode_e;

  localparam logic [2:0] AM_NOUPD = 3'b100;
  localparam logic [2:0] AM_INC   = 3'b101;

  typedef struct packed {
    logic [2:0]  src_mode;
    logic [2:0]  dst_mode;
    logic        tri_en;
    logic        tri_dst;
    tri_layout_e layout;
    logic        pair;
  } chan_cfg_t;

endpackage

// File: rtl/mdma_counter.sv
module mdma_counter
  import mdma_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] cnt_in,
  input  logic          step,
  input  cnt_mode_e     mode,
  input  tri_layout_e   layout,
  output logic [CW-1:0] cnt,
  output logic          z_lo,
  output logic          z_mid,
  output logic          last
);

  localparam int HALF = CW / 2;
  localparam int QTR  = CW / 4;
  localparam logic [CW-1:0] ONES = '1;
  localparam logic [CW-1:0] M_Q  = ONES >> (CW - QTR);
  localparam logic [CW-1:0] M_H  = ONES >> (CW - HALF);
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] pre;
  logic [CW-1:0] lo_mask, mid_mask, lo_unit, hi_unit, nxt;

  // field geometry for the active counter split
  always_comb begin
    lo_mask  = ONES;
    mid_mask = '0;
    lo_unit  = ONE;
    hi_unit  = ONE;
    case (mode)
      CM_DUAL: begin
        lo_mask = M_H;
        lo_unit = ONE << HALF;
        hi_unit = ONE << HALF;
      end
      CM_TRIPLE: begin
        case (layout)
          LAY_D: begin
            lo_mask  = M_Q;
            mid_mask = M_H << QTR;
            lo_unit  = ONE << QTR;
            hi_unit  = ONE << (QTR + HALF);
          end
          LAY_E: begin
            lo_mask  = M_H;
            mid_mask = M_Q << HALF;
            lo_unit  = ONE << HALF;
            hi_unit  = ONE << (HALF + QTR);
          end
          default: begin
            lo_mask  = M_Q;
            mid_mask = M_Q << QTR;
            lo_unit  = ONE << QTR;
            hi_unit  = ONE << (2 * QTR);
          end
        endcase
      end
      default: ;
    endcase
  end

  assign z_lo  = (cnt & lo_mask) == '0;
  assign z_mid = (cnt & mid_mask) == '0;
  assign last  = cnt == '0;

  always_comb begin
    if (!z_lo)
      nxt = cnt - ONE;
    else if (!z_mid)
      nxt = ((cnt - lo_unit) & ~lo_mask) | (pre & lo_mask);
    else if (!last)
      nxt = ((cnt - hi_unit) & ~(lo_mask | mid_mask)) | (pre & (lo_mask | mid_mask));
    else
      nxt = pre;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      pre <= '0;
    end else if (load) begin
      cnt <= cnt_in;
      pre <= cnt_in;
    end else if (step) begin
      cnt <= nxt;
    end
  end

endmodule

// File: rtl/mdma_addr_side.sv
module mdma_addr_side
  import mdma_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [AW-1:0]      start_addr,
  input  logic               step,
  input  logic [2:0]         mode,
  input  logic               is3d,
  input  logic               pair,
  input  logic [3:0][AW-1:0] offs,
  input  logic               z_lo,
  input  logic               z_mid,
  output logic [AW-1:0]      addr
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] delta;

  always_comb begin
    delta = '0;
    if (is3d) begin
      if (!z_lo)       delta = ONE;
      else if (!z_mid) delta = offs[{pair, 1'b0}];
      else             delta = offs[{pair, 1'b1}];
    end else if (!mode[2]) begin
      delta = z_lo ? offs[mode[1:0]] : ONE;
    end else if (mode == AM_INC) begin
      delta = ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= start_addr;
    else if (step) addr <= addr + delta;
  end

endmodule

// File: rtl/mdma_addr_gen.sv
module mdma_addr_gen
  import mdma_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic            start_i,
  input  logic            advance_i,
  input  logic [AW-1:0]   src_start_i,
  input  logic [AW-1:0]   dst_start_i,
  input  logic [CW-1:0]   count_i,
  input  logic [2:0]      src_mode_i,
  input  logic [2:0]      dst_mode_i,
  input  logic            tri_en_i,
  input  logic            tri_dst_i,
  input  logic [1:0]      tri_layout_i,
  input  logic            tri_pair_i,
  input  logic [4*AW-1:0] offsets_i,
  output logic [AW-1:0]   src_addr_o,
  output logic [AW-1:0]   dst_addr_o,
  output logic [CW-1:0]   count_o,
  output logic            done_o,
  output logic            busy_o
);

  localparam int NSIDE = 2;

  chan_cfg_t          cfg;
  cnt_mode_e          cmode;
  logic               acc_load, step, z_lo, z_mid, last;
  logic [3:0][AW-1:0] offs;
  logic [AW-1:0]      side_start [NSIDE];
  logic [2:0]         side_mode  [NSIDE];
  logic [AW-1:0]      side_addr  [NSIDE];

  assign offs     = offsets_i;
  assign acc_load = load_i & ~busy_o;
  assign step     = advance_i & busy_o;

  always_ff @(posedge clk) begin
    if (rst) cfg <= '0;
    else if (acc_load)
      cfg <= '{src_mode: src_mode_i, dst_mode: dst_mode_i, tri_en: tri_en_i,
               tri_dst: tri_dst_i, layout: tri_layout_e'(tri_layout_i),
               pair: tri_pair_i};
  end

  always_comb begin
    if (cfg.tri_en)                              cmode = CM_TRIPLE;
    else if (!cfg.src_mode[2] || !cfg.dst_mode[2]) cmode = CM_DUAL;
    else                                         cmode = CM_SINGLE;
  end

  mdma_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load   (acc_load),
    .cnt_in (count_i),
    .step   (step),
    .mode   (cmode),
    .layout (cfg.layout),
    .cnt    (count_o),
    .z_lo   (z_lo),
    .z_mid  (z_mid),
    .last   (last)
  );

  assign side_start[0] = src_start_i;
  assign side_start[1] = dst_start_i;
  assign side_mode[0]  = cfg.src_mode;
  assign side_mode[1]  = cfg.dst_mode;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    mdma_addr_side #(.AW(AW)) u_side (
      .clk        (clk),
      .rst        (rst),
      .load       (acc_load),
      .start_addr (side_start[g]),
      .step       (step),
      .mode       (side_mode[g]),
      .is3d       (cfg.tri_en && (cfg.tri_dst == (g == 1))),
      .pair       (cfg.pair),
      .offs       (offs),
      .z_lo       (z_lo),
      .z_mid      (z_mid),
      .addr       (side_addr[g])
    );
  end

  assign src_addr_o = side_addr[0];
  assign dst_addr_o = side_addr[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= step & last;
      if (step && last)         busy_o <= 1'b0;
      else if (start_i && !busy_o) busy_o <= 1'b1;
    end
  end

endmodule

// File: rtl/mdma_addr_gen_chk.sv
module mdma_addr_gen_chk #(
  parameter int AW = 24,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          load_i,
  input logic          advance_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] count_o,
  input logic [AW-1:0] src_addr_o,
  input logic [AW-1:0] dst_addr_o
);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !load_i) |=> ($stable(count_o) && $stable(src_addr_o) && $stable(dst_addr_o)));

  p_busy_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !advance_i) |=> ($stable(count_o) && $stable(src_addr_o) && $stable(dst_addr_o)));

  p_last_word_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && advance_i && count_o == '0) |=> (done_o && !busy_o));

  p_mid_word_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && advance_i && count_o != '0) |=> (!done_o && busy_o && count_o != $past(count_o)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

bind mdma_addr_gen mdma_addr_gen_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load_i     (load_i),
  .advance_i  (advance_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .count_o    (count_o),
  .src_addr_o (src_addr_o),
  .dst_addr_o (dst_addr_o)
);

// File: tb/mdma_addr_gen_tb.sv
module mdma_addr_gen_tb;

  localparam int AW = 24;
  localparam int CW = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_i = 0, start_i = 0, advance_i = 0;
  logic [AW-1:0] src_start_i = 0, dst_start_i = 0;
  logic [CW-1:0] count_i = 0;
  logic [2:0] src_mode_i = 0, dst_mode_i = 0;
  logic tri_en_i = 0, tri_dst_i = 0, tri_pair_i = 0;
  logic [1:0] tri_layout_i = 0;
  logic [4*AW-1:0] offsets_i = 0;
  logic [AW-1:0] src_addr_o, dst_addr_o;
  logic [CW-1:0] count_o;
  logic done_o, busy_o;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mdma_addr_gen #(.AW(AW), .CW(CW)) u_dut (.*);

  // dual mode walk: src 2D offset0 = 0x10, start 0x100; dst +1 from 0x800; high=1 low=2
  // fields: src, dst, count, done
  localparam logic [72:0] VEC [0:5] = '{
    {24'h000101, 24'h000801, 24'h001001, 1'b0},
    {24'h000102, 24'h000802, 24'h001000, 1'b0},
    {24'h000112, 24'h000803, 24'h000002, 1'b0},
    {24'h000113, 24'h000804, 24'h000001, 1'b0},
    {24'h000114, 24'h000805, 24'h000000, 1'b0},
    {24'h000124, 24'h000806, 24'h001002, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic set_offs(input logic [23:0] o0, o1, o2, o3);
    offsets_i = {o3, o2, o1, o0};
  endtask

  task automatic do_load(input logic [23:0] sa, da, cnt, input logic [2:0] sm, dm,
                         input logic te, td, input logic [1:0] lay, input logic pr,
                         input logic go);
    @(negedge clk);
    src_start_i = sa; dst_start_i = da; count_i = cnt;
    src_mode_i = sm; dst_mode_i = dm; tri_en_i = te; tri_dst_i = td;
    tri_layout_i = lay; tri_pair_i = pr; load_i = 1; start_i = go;
    @(negedge clk);
    load_i = 0; start_i = 0;
  endtask

  task automatic adv(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      advance_i = 1;
      @(negedge clk);
      advance_i = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 src", src_addr_o, 0);
    chk("R1 dst", dst_addr_o, 0);
    chk("R1 count", count_o, 0);
    chk("R1 done/busy", {done_o, busy_o}, 0);

    // R5 / R10 table walk
    set_offs(24'h10, 24'h7000, 24'h8000, 24'h9000);
    do_load(24'h100, 24'h800, 24'h001002, 3'b000, 3'b101, 0, 0, 2'b00, 0, 1);
    for (int v = 0; v < 6; v++) begin
      adv(1);
      chk("R5 src", src_addr_o, VEC[v][72:49]);
      chk("R10 dst", dst_addr_o, VEC[v][48:25]);
      chk("R5 count", count_o, VEC[v][24:1]);
      chk("R5 done", done_o, VEC[v][0]);
    end
    chk("R3 busy cleared", busy_o, 0);

    // R3 / R4 single mode
    do_load(24'h10, 24'h20, 24'h2, 3'b101, 3'b100, 0, 0, 2'b00, 0, 1);
    adv(1);
    chk("R3 count dec", count_o, 1);
    chk("R4 inc", src_addr_o, 24'h11);
    chk("R4 noupdate", dst_addr_o, 24'h20);
    adv(2);
    chk("R3 reload", count_o, 2);
    chk("R3 done", done_o, 1);
    chk("R3 idle", busy_o, 0);
    chk("R4 inc end", src_addr_o, 24'h13);
    @(negedge clk);
    chk("R11 done pulse", done_o, 0);

    // R11 advance while idle
    adv(2);
    chk("R11 idle count", count_o, 2);
    chk("R11 idle src", src_addr_o, 24'h13);

    // R2 load while busy ignored
    do_load(24'h0, 24'h0, 24'h3, 3'b101, 3'b101, 0, 0, 2'b00, 0, 1);
    adv(1);
    do_load(24'h77, 24'h77, 24'h9, 3'b101, 3'b101, 0, 0, 2'b00, 0, 0);
    chk("R2 busy count", count_o, 2);
    chk("R2 busy src", src_addr_o, 1);
    adv(3);
    chk("R2 preload kept", count_o, 3);
    chk("R2 done", done_o, 1);

    // R6 offset select
    set_offs(24'h11, 24'h1111, 24'h22, 24'h333);
    do_load(24'h1000, 24'h0, 24'h0, 3'b011, 3'b100, 0, 0, 2'b00, 0, 1);
    adv(1);
    chk("R6 off3", src_addr_o, 24'h1333);
    do_load(24'h1000, 24'h0, 24'h0, 3'b010, 3'b100, 0, 0, 2'b00, 0, 1);
    adv(1);
    chk("R6 off2", src_addr_o, 24'h1022);

    // R7 circular buffer of four words and wrap below zero
    set_offs(24'h5, 24'hFFFFFD, 24'h0, 24'h0);
    do_load(24'h40, 24'h0, 24'h001003, 3'b001, 3'b100, 0, 0, 2'b00, 0, 1);
    adv(4);
    chk("R7 wrap back", src_addr_o, 24'h40);
    chk("R7 count", count_o, 24'h000003);
    adv(4);
    chk("R7 second lap", src_addr_o, 24'h40);
    chk("R7 done", done_o, 1);
    set_offs(24'hFFFFFE, 24'h0, 24'h0, 24'h0);
    do_load(24'h1, 24'h0, 24'h0, 3'b000, 3'b100, 0, 0, 2'b00, 0, 1);
    adv(1);
    chk("R7 below zero", src_addr_o, 24'hFFFFFF);

    // R8 / R9 layout C, source 3D, pair 0, dst 2D on low field
    set_offs(24'h100, 24'h2000, 24'h40000, 24'h80000);
    do_load(24'h1000, 24'h500, 24'h001042, 3'b111, 3'b000, 1, 0, 2'b00, 0, 1);
    adv(3);
    chk("R8 C src3", src_addr_o, 24'h1102);
    chk("R9 dst low field", dst_addr_o, 24'h602);
    chk("R8 C count3", count_o, 24'h001002);
    adv(3);
    chk("R8 C src6", src_addr_o, 24'h3104);
    chk("R8 C count6", count_o, 24'h000042);
    chk("R9 dst6", dst_addr_o, 24'h704);
    adv(6);
    chk("R8 C src end", src_addr_o, 24'h5208);
    chk("R8 C done", done_o, 1);
    chk("R8 C reload", count_o, 24'h001042);
    chk("R9 dst end", dst_addr_o, 24'h908);

    // R8 / R9 layout E, destination 3D, pair 1
    set_offs(24'h1, 24'h2, 24'h20, 24'h300);
    do_load(24'hABC, 24'h10, 24'h001000, 3'b100, 3'b101, 1, 1, 2'b10, 1, 1);
    adv(1);
    chk("R8 E first offset", dst_addr_o, 24'h30);
    chk("R9 src const", src_addr_o, 24'hABC);
    adv(1);
    chk("R8 E second offset", dst_addr_o, 24'h330);
    chk("R8 E done", done_o, 1);
    chk("R8 E reload", count_o, 24'h001000);

    // R8 layout D with mid field at bits 17:6
    do_load(24'hABC, 24'h10, 24'h000040, 3'b100, 3'b101, 1, 1, 2'b01, 1, 1);
    adv(1);
    chk("R8 D first offset", dst_addr_o, 24'h30);
    adv(1);
    chk("R8 D second offset", dst_addr_o, 24'h330);
    chk("R8 D done", done_o, 1);

    report();
    $finish;
  end

endmodule